// File: doc/BRIEF.md
# Predicate File with Broadside Transfer

This block stores the one-bit predicates of a processor core. There are 64 entries. Entry 0 is tied to true. Entries 1 to 15 are static. Entries 16 to 63 form a rotating group.

Single predicates are read and written by logical index. Logical indices in the rotating group are offset by a 6-bit rotation base before they reach storage. Two write ports and two read ports serve this path.

Two broadside operations handle the whole file at once, and both ignore the rotation base:
- A broadside read drives the whole file onto a 64-bit word.
- A broadside write loads entries from a 64-bit word under a 17-bit mask. The mask has one bit per static entry and a single bit for the whole rotating group.

The rotation base comes from outside. The block only observes it and never changes it.

Top module: `pred_file_bcast`

## Requirements
- R1: Entry 0 always reads as 1, on the read ports and on bit 0 of the broadside word. Writes to logical index 0, from any port, change nothing.
- R2: The broadside read word is combinational from the stored state. Bit N holds entry N.
- R3: On a broadside write, mask bit k (1 ≤ k ≤ 15) enables loading entry k from word bit k. Mask bit 0 has no effect.
- R4: On a broadside write, mask bit 16 enables loading every entry 16 to 63 from the word bit with the same number.
- R5: An entry whose broadside mask bit is clear keeps its previous value.
- R6: Broadside writes and reads use physical numbering and do not depend on the rotation base input.
- R7: A single-predicate read or write of logical index i ≥ 16 reaches physical entry 16 + ((i − 16 + rrb) mod 48), where rrb is the 6-bit base input. This holds for bases of 48 and above.
- R8: Logical indices 0 to 15 map to the physical entry with the same number, whatever the base.
- R9: When both single write ports are enabled and reach the same physical entry, port 1's value is stored.
- R10: When a broadside write and single writes happen in the same cycle, only the broadside write takes effect.
- R11: A synchronous reset clears entries 1 to 63 to 0. The broadside word then reads 64'h1.
- R12: Writes take effect at the rising clock edge. They are visible on the outputs in the following cycle and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rrb | input | 6 | Rotation base for single-predicate accesses |
| rd_idx0 | input | 6 | Logical index, read port 0 |
| rd_val0 | output | 1 | Predicate value, read port 0 |
| rd_idx1 | input | 6 | Logical index, read port 1 |
| rd_val1 | output | 1 | Predicate value, read port 1 |
| wr_en0 | input | 1 | Write enable, port 0 |
| wr_idx0 | input | 6 | Logical index, write port 0 |
| wr_val0 | input | 1 | Write data, port 0 |
| wr_en1 | input | 1 | Write enable, port 1 (priority) |
| wr_idx1 | input | 6 | Logical index, write port 1 |
| wr_val1 | input | 1 | Write data, port 1 |
| bs_wr_en | input | 1 | Broadside write strobe |
| bs_mask | input | 17 | Broadside mask: bits 1-15 static, bit 16 rotating group, bit 0 unused |
| bs_wr_word | input | 64 | Broadside write data, bit N to entry N |
| bs_rd_word | output | 64 | Broadside read data, entry N on bit N |

## Verification
Directed broadside writes use several mask patterns:
- All bits set.
- All bits clear.
- Only bit 0.
- Only the rotating bit.

These separate the per-entry static decode from the group enable and the ignored bit. They run under a non-zero rotation base, to show the base is ignored there.

Single writes are made at rotation bases 0, 47, 48 and 63. These expose the wrap of the modulo-48 mapping, and show that static indices stay unrotated.

Same-index dual writes, and single writes that coincide with a broadside write, test the two write priorities. A long random run then mixes all operations with occasional resets.

// File: rtl/pred_bcast_pkg.sv
package pred_bcast_pkg;
  localparam int unsigned PB_NUM_PRED   = 64;
  localparam int unsigned PB_NUM_STATIC = 16;
  localparam int unsigned PB_IDX_W      = $clog2(PB_NUM_PRED);
  localparam int unsigned PB_MASK_W     = PB_NUM_STATIC + 1;
  localparam int unsigned PB_NUM_WRP    = 2;
  localparam int unsigned PB_NUM_RDP    = 2;

  typedef struct packed {
    logic                en;
    logic [PB_IDX_W-1:0] phys;
    logic                val;
  } pb_wr_t;
endpackage

// File: rtl/pred_rot_map.sv
module pred_rot_map #(
  parameter int unsigned NUM_PRED   = 64,
  parameter int unsigned NUM_STATIC = 16,
  parameter int unsigned IDX_W      = $clog2(NUM_PRED)
) (
  input  logic [IDX_W-1:0] logical_idx,
  input  logic [IDX_W-1:0] rot_base,
  output logic [IDX_W-1:0] phys_idx
);
  localparam int unsigned ROT_N = NUM_PRED - NUM_STATIC;

  // Offset into rotating region plus base, reduced modulo region size.
  function automatic logic [IDX_W-1:0] to_phys(input logic [IDX_W-1:0] li,
                                               input logic [IDX_W-1:0] base);
    logic [IDX_W:0] off;
    if (li < IDX_W'(NUM_STATIC)) return li;
    off = {1'b0, li} - (IDX_W+1)'(NUM_STATIC) + {1'b0, base};
    off = off % (IDX_W+1)'(ROT_N);
    return IDX_W'(off + (IDX_W+1)'(NUM_STATIC));
  endfunction

  assign phys_idx = to_phys(logical_idx, rot_base);
endmodule

// File: rtl/pred_mask_decode.sv
module pred_mask_decode #(
  parameter int unsigned NUM_PRED   = 64,
  parameter int unsigned NUM_STATIC = 16,
  parameter int unsigned MASK_W     = NUM_STATIC + 1
) (
  input  logic [MASK_W-1:0]   mask,
  output logic [NUM_PRED-1:0] ent_en
);
  localparam int unsigned GRP_BIT = MASK_W - 1;

  for (genvar n = 0; n < NUM_PRED; n++) begin : g_ent
    if (n == 0) begin : g_zero
      assign ent_en[n] = 1'b0;
    end else if (n < NUM_STATIC) begin : g_static
      assign ent_en[n] = mask[n];
    end else begin : g_rot
      assign ent_en[n] = mask[GRP_BIT];
    end
  end
endmodule

// File: rtl/pred_store.sv
module pred_store
  import pred_bcast_pkg::*;
#(
  parameter int unsigned NUM_PRED = 64,
  parameter int unsigned NUM_WRP  = 2,
  parameter int unsigned IDX_W    = $clog2(NUM_PRED)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bs_wr_en,
  input  logic [NUM_PRED-1:0] bs_ent_en,
  input  logic [NUM_PRED-1:0] bs_word,
  input  pb_wr_t              wr_port [NUM_WRP],
  output logic [NUM_PRED-1:0] state,
  output logic [NUM_PRED-1:0] single_hit
);
  logic [NUM_PRED-1:0] store_q;
  logic [NUM_PRED-1:0] single_val;

  assign store_q[0] = 1'b1;

  for (genvar n = 1; n < NUM_PRED; n++) begin : g_ent
    // Later port wins: walk ports in ascending order, last match kept.
    always_comb begin
      single_hit[n] = 1'b0;
      single_val[n] = store_q[n];
      for (int p = 0; p < int'(NUM_WRP); p++) begin
        if (wr_port[p].en && wr_port[p].phys == IDX_W'(n)) begin
          single_hit[n] = 1'b1;
          single_val[n] = wr_port[p].val;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                         store_q[n] <= 1'b0;
      else if (bs_wr_en) begin
        if (bs_ent_en[n])              store_q[n] <= bs_word[n];
      end else if (single_hit[n])      store_q[n] <= single_val[n];
    end
  end

  assign single_hit[0] = 1'b0;
  assign single_val[0] = 1'b1;
  assign state         = store_q;
endmodule

// File: rtl/pred_file_bcast.sv
module pred_file_bcast
  import pred_bcast_pkg::*;
#(
  parameter int unsigned NUM_PRED   = PB_NUM_PRED,
  parameter int unsigned NUM_STATIC = PB_NUM_STATIC,
  parameter int unsigned IDX_W      = PB_IDX_W,
  parameter int unsigned MASK_W     = PB_MASK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    rrb,
  input  logic [IDX_W-1:0]    rd_idx0,
  output logic                rd_val0,
  input  logic [IDX_W-1:0]    rd_idx1,
  output logic                rd_val1,
  input  logic                wr_en0,
  input  logic [IDX_W-1:0]    wr_idx0,
  input  logic                wr_val0,
  input  logic                wr_en1,
  input  logic [IDX_W-1:0]    wr_idx1,
  input  logic                wr_val1,
  input  logic                bs_wr_en,
  input  logic [MASK_W-1:0]   bs_mask,
  input  logic [NUM_PRED-1:0] bs_wr_word,
  output logic [NUM_PRED-1:0] bs_rd_word
);
  localparam int unsigned NUM_MAP = PB_NUM_WRP + PB_NUM_RDP;

  logic [NUM_MAP-1:0][IDX_W-1:0] map_in, map_out;
  logic [IDX_W-1:0]    phys_w0, phys_w1, phys_r0, phys_r1;
  logic [NUM_PRED-1:0] bs_ent_en;
  logic [NUM_PRED-1:0] pstate;
  logic [NUM_PRED-1:0] single_hit;
  pb_wr_t              wr_port [PB_NUM_WRP];

  assign map_in = {rd_idx1, rd_idx0, wr_idx1, wr_idx0};

  for (genvar p = 0; p < NUM_MAP; p++) begin : g_map
    pred_rot_map #(
      .NUM_PRED(NUM_PRED), .NUM_STATIC(NUM_STATIC), .IDX_W(IDX_W)
    ) u_map (
      .logical_idx(map_in[p]),
      .rot_base   (rrb),
      .phys_idx   (map_out[p])
    );
  end

  assign phys_w0 = map_out[0];
  assign phys_w1 = map_out[1];
  assign phys_r0 = map_out[2];
  assign phys_r1 = map_out[3];

  assign wr_port[0] = '{en: wr_en0, phys: phys_w0, val: wr_val0};
  assign wr_port[1] = '{en: wr_en1, phys: phys_w1, val: wr_val1};

  pred_mask_decode #(
    .NUM_PRED(NUM_PRED), .NUM_STATIC(NUM_STATIC), .MASK_W(MASK_W)
  ) u_dec (
    .mask  (bs_mask),
    .ent_en(bs_ent_en)
  );

  pred_store #(
    .NUM_PRED(NUM_PRED), .NUM_WRP(PB_NUM_WRP), .IDX_W(IDX_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .bs_wr_en  (bs_wr_en),
    .bs_ent_en (bs_ent_en),
    .bs_word   (bs_wr_word),
    .wr_port   (wr_port),
    .state     (pstate),
    .single_hit(single_hit)
  );

  assign rd_val0    = pstate[phys_r0];
  assign rd_val1    = pstate[phys_r1];
  assign bs_rd_word = pstate;
endmodule

// File: rtl/pred_bcast_chk.sv
module pred_bcast_chk #(
  parameter int unsigned NUM_PRED   = 64,
  parameter int unsigned NUM_STATIC = 16,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned MASK_W     = 17
) (
  input logic                clk,
  input logic                rst,
  input logic [IDX_W-1:0]    rd_idx0,
  input logic                rd_val0,
  input logic                wr_en0,
  input logic                wr_val0,
  input logic                wr_en1,
  input logic                wr_val1,
  input logic [IDX_W-1:0]    phys_w0,
  input logic [IDX_W-1:0]    phys_w1,
  input logic                bs_wr_en,
  input logic [MASK_W-1:0]   bs_mask,
  input logic [NUM_PRED-1:0] bs_wr_word,
  input logic [NUM_PRED-1:0] bs_rd_word
);
  localparam int unsigned G = MASK_W - 1;

  AST_STATIC_READ_MATCH: assert property (@(posedge clk) disable iff (rst)
    (rd_idx0 < IDX_W'(NUM_STATIC)) |-> rd_val0 == bs_rd_word[rd_idx0]); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> bs_rd_word == NUM_PRED'(1)); // R11

  AST_GROUP_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bs_wr_en && bs_mask[G])
      |-> bs_rd_word[NUM_PRED-1:NUM_STATIC] == $past(bs_wr_word[NUM_PRED-1:NUM_STATIC])); // R4

  AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bs_wr_en && !bs_mask[G])
      |-> bs_rd_word[NUM_PRED-1:NUM_STATIC] == $past(bs_rd_word[NUM_PRED-1:NUM_STATIC])); // R10

  AST_STATIC_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bs_wr_en && !bs_mask[1])
      |-> bs_rd_word[1] == $past(bs_rd_word[1])); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !bs_wr_en && !wr_en0 && !wr_en1) |-> $stable(bs_rd_word)); // R12

  AST_PORT1_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !bs_wr_en && wr_en0 && wr_en1 && phys_w0 == phys_w1 && phys_w1 != '0)
      |-> bs_rd_word[$past(phys_w1)] == $past(wr_val1)); // R9

  AST_ENTRY0_SET: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && (wr_en0 && !wr_val0) && phys_w0 == '0) |-> bs_rd_word[0]); // R1
endmodule

bind pred_file_bcast pred_bcast_chk #(
  .NUM_PRED(NUM_PRED), .NUM_STATIC(NUM_STATIC), .IDX_W(IDX_W), .MASK_W(MASK_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_idx0(rd_idx0), .rd_val0(rd_val0),
  .wr_en0(wr_en0), .wr_val0(wr_val0), .wr_en1(wr_en1), .wr_val1(wr_val1),
  .phys_w0(phys_w0), .phys_w1(phys_w1), .bs_wr_en(bs_wr_en),
  .bs_mask(bs_mask), .bs_wr_word(bs_wr_word), .bs_rd_word(bs_rd_word)
);

// File: tb/test_pred_file_bcast.sv
`timescale 1ns/1ps
module test_pred_file_bcast;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  rrb = '0, rd_idx0 = '0, rd_idx1 = '0, wr_idx0 = '0, wr_idx1 = '0;
  logic        rd_val0, rd_val1;
  logic        wr_en0 = 1'b0, wr_val0 = 1'b0, wr_en1 = 1'b0, wr_val1 = 1'b0;
  logic        bs_wr_en = 1'b0;
  logic [16:0] bs_mask = '0;
  logic [63:0] bs_wr_word = '0;
  logic [63:0] bs_rd_word;

  int n_chk = 0, n_bad = 0;
  logic [63:0] mdl;

  always #2 clk = ~clk;

  pred_file_bcast i_pred_file_bcast (
    .clk(clk), .rst(rst), .rrb(rrb),
    .rd_idx0(rd_idx0), .rd_val0(rd_val0), .rd_idx1(rd_idx1), .rd_val1(rd_val1),
    .wr_en0(wr_en0), .wr_idx0(wr_idx0), .wr_val0(wr_val0),
    .wr_en1(wr_en1), .wr_idx1(wr_idx1), .wr_val1(wr_val1),
    .bs_wr_en(bs_wr_en), .bs_mask(bs_mask), .bs_wr_word(bs_wr_word),
    .bs_rd_word(bs_rd_word)
  );

  function automatic int bench_phys(int li, int base);
    if (li < 16) return li;
    return 16 + ((li - 16 + base) % 48);
  endfunction

  function automatic logic [63:0] bench_next(logic [63:0] cur);
    logic [63:0] nx = cur;
    if (rst) return 64'h1;
    if (bs_wr_en) begin
      for (int n = 1; n < 64; n++)
        if ((n < 16) ? bs_mask[n] : bs_mask[16]) nx[n] = bs_wr_word[n];
    end else begin
      if (wr_en0 && wr_idx0 != 0) nx[bench_phys(wr_idx0, rrb)] = wr_val0;
      if (wr_en1 && wr_idx1 != 0) nx[bench_phys(wr_idx1, rrb)] = wr_val1;
    end
    nx[0] = 1'b1;
    return nx;
  endfunction

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Inputs are set after a falling edge; check, then clock and advance model.
  task automatic step(string tag);
    #1;
    cmp(tag, "bs_rd_word", bs_rd_word, mdl);
    cmp(tag, "rd_val0", 64'(rd_val0), 64'(mdl[bench_phys(rd_idx0, rrb)]));
    cmp(tag, "rd_val1", 64'(rd_val1), 64'(mdl[bench_phys(rd_idx1, rrb)]));
    @(posedge clk);
    mdl = bench_next(mdl);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en0 = 0; wr_en1 = 0; bs_wr_en = 0; rst = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    mdl = 64'h1;
    @(negedge clk);
    @(posedge clk); @(negedge clk);
    mdl = 64'h1;
    idle();
    step("R11");                       // reset state: only entry 0 set
    cmp("R11", "reset word", bs_rd_word, 64'h1);

    // R1: write 0 to index 0 from both ports
    wr_en0 = 1; wr_idx0 = 0; wr_val0 = 0; wr_en1 = 1; wr_idx1 = 0; wr_val1 = 0;
    rd_idx0 = 0; step("R1"); idle(); step("R1");

    // R3/R4/R6: all-ones broadside under a non-zero base
    rrb = 37; bs_wr_en = 1; bs_mask = 17'h1FFFF; bs_wr_word = '0 - 64'd1;
    step("R3"); idle(); step("R4");
    cmp("R6", "all ones", bs_rd_word, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5: clear mask keeps everything
    bs_wr_en = 1; bs_mask = '0; bs_wr_word = '0; step("R5"); idle(); step("R5");
    // R3: mask bit 0 alone is ignored
    bs_wr_en = 1; bs_mask = 17'h1; step("R3"); idle(); step("R3");
    cmp("R3", "bit0 ignored", bs_rd_word, 64'hFFFF_FFFF_FFFF_FFFF);
    // R4: rotating bit only
    bs_wr_en = 1; bs_mask = 17'h10000; step("R4"); idle(); step("R4");
    cmp("R4", "group cleared", bs_rd_word, 64'h0000_0000_0000_FFFF);

    // R7/R8/R12: rotated single writes
    rrb = 47; wr_en0 = 1; wr_idx0 = 16; wr_val0 = 1; rd_idx0 = 16;
    cmp("R12", "before edge", 64'(bs_rd_word[63]), 64'h0);
    step("R12"); idle(); step("R7");
    cmp("R7", "rrb47 idx16->63", 64'(bs_rd_word[63]), 64'h1);
    rrb = 48; wr_en0 = 1; wr_idx0 = 20; step("R7"); idle(); step("R7");
    cmp("R7", "rrb48 idx20->20", 64'(bs_rd_word[20]), 64'h1);
    rrb = 63; wr_en0 = 1; wr_idx0 = 63; step("R7"); idle(); step("R7");
    cmp("R7", "rrb63 idx63->30", 64'(bs_rd_word[30]), 64'h1);
    wr_en0 = 1; wr_idx0 = 5; wr_val0 = 0; rd_idx1 = 5; step("R8"); idle(); step("R8");
    cmp("R8", "static unrotated", 64'(bs_rd_word[5]), 64'h0);

    // R9: same target, port 1 wins
    rrb = 10; wr_en0 = 1; wr_idx0 = 40; wr_val0 = 1; wr_en1 = 1; wr_idx1 = 40; wr_val1 = 0;
    step("R9"); idle(); step("R9");
    cmp("R9", "port1 value", 64'(bs_rd_word[bench_phys(40, 10)]), 64'h0);

    // R10: broadside with empty mask blocks single writes
    wr_en0 = 1; wr_idx0 = 3; wr_val0 = 0; wr_en1 = 1; wr_idx1 = 50; wr_val1 = 1;
    bs_wr_en = 1; bs_mask = '0; step("R10"); idle(); step("R10");
    cmp("R10", "entry3 kept", 64'(bs_rd_word[3]), 64'h1);

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      rst      = ($urandom % 200) == 0;
      rrb      = 6'($urandom); rd_idx0 = 6'($urandom); rd_idx1 = 6'($urandom);
      wr_en0   = 1'($urandom); wr_idx0 = 6'($urandom); wr_val0 = 1'($urandom);
      wr_en1   = 1'($urandom); wr_idx1 = ($urandom % 4 == 0) ? wr_idx0 : 6'($urandom);
      wr_val1  = 1'($urandom);
      bs_wr_en = ($urandom % 8) == 0;
      bs_mask  = 17'($urandom); bs_wr_word = {$urandom, $urandom};
      step("R2/R7/R9/R10");
    end
    idle(); step("R2");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule